// File: doc/BRIEF.md
# Segment-Wrap Serial Flash Read Engine

This block is the slave-side read path of a serial flash memory on a four-wire SPI bus (active-low select, serial clock, serial data in, serial data out). While the select line is low, a host shifts in an 8-bit opcode and then a 24-bit byte address, MSB first. If the opcode is the read opcode, the block streams bytes MSB first for as long as select stays low. The bytes come from a 1M x 8 array. Only the low 20 address bits are used.

The 20-bit array address has two parts. The upper 11 bits name one of 2048 segments of 512 bytes and stay fixed for the whole burst. The lower 9 bits preset a byte counter. That counter steps once per byte and rolls from 511 back to 0 inside the same segment, so a read that starts anywhere keeps circling its segment. The array content is a computed function of the address, which stands in for storage. The SPI pins are oversampled by the block clock through a synchroniser, and SCLK edges are detected in that clock domain. The SCLK high and low phases must each last at least four block clock cycles.

The controller has five states:
- IDLE: deselected.
- CMD: shifting the opcode.
- ADDR: shifting the address.
- DATA: streaming bytes.
- IGNORE: an unknown opcode was received.

Transitions:
- IDLE to CMD when select goes low.
- CMD to ADDR on the eighth SCLK rise when the opcode matches.
- CMD to IGNORE on the eighth SCLK rise when it does not.
- ADDR to DATA on the 24th address rise.
- Any state to IDLE when select goes high.

Top module: `seg_wrap_reader`

## Requirements
- R1: After reset, and no later than four clock cycles after cs_n goes high, so_oe is 0 and so is 0.
- R2: si is sampled on SCLK rising edges. The first 8 bits form the opcode and the next 24 bits form the address, both MSB first. Opcode 0x03 selects read.
- R3: In a read, the first data bit is driven after the SCLK falling edge that follows the 32nd rising edge. Each data bit then changes after a falling edge, and every byte goes out MSB first.
- R4: The byte at 20-bit address a is a[7:0] ^ a[15:8] ^ {4'b0, a[19:16]} ^ 0xA5. Address bits 23:20 are ignored.
- R5: The first byte of a read is the one at the given address, whatever its offset within the segment. Each following byte is at the next offset.
- R6: After offset 511 the offset returns to 0. Address bits 19:9 (the segment) never change during a burst.
- R7: Output continues without a byte limit while cs_n stays low, including more than one full lap of a segment.
- R8: Raising cs_n at any point abandons the access. The next selection starts again from the opcode.
- R9: After an opcode other than 0x03, so_oe stays 0 until cs_n goes high. The next selection is decoded normally.
- R10: During a read, so_oe is 1 from the first data falling edge until deselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, 0 when not driven |
| so_oe | output | 1 | High while so carries read data |

## Verification
Each pin passes through two synchroniser flops, and one more register either detects the edge or loads the output shift register. As a result, so changes three block clock cycles after the host's SCLK fall. so_oe falls within four cycles after cs_n goes high. The bench holds each SCLK phase for four cycles and reads so at the next rising SCLK edge, one cycle after the data settles. It also waits six cycles after each deselection before checking the idle outputs. Expected bytes are queued as each burst begins and are compared byte by byte in SCLK rise order.

// File: rtl/segrd_pkg.sv
`timescale 1ns/1ps
package segrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DATA   = 3'd3,
        ST_IGNORE = 3'd4
    } segrd_state_e;

endpackage

// File: rtl/segrd_sync.sv
`timescale 1ns/1ps
module segrd_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/segrd_fsm.sv
`timescale 1ns/1ps
module segrd_fsm
    import segrd_pkg::*;
#(
    parameter int          CMD_W       = 8,
    parameter int          ADDR_W      = 24,
    parameter logic [7:0]  READ_OPCODE = 8'h03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               si_s,
    output segrd_state_e       state,
    output logic               sclk_fall,
    output logic               addr_load,
    output logic [ADDR_W-1:0]  addr_word
);

    localparam int LONGEST = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
    localparam int CNT_W   = $clog2(LONGEST);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);

    segrd_state_e        state_nx;
    logic                sclk_q;
    logic                sclk_rise;
    logic [CNT_W-1:0]    bit_cnt;
    logic [LONGEST-1:0]  in_sr;
    logic [LONGEST-1:0]  shift_next;
    logic                shifting;
    logic                cmd_done;
    logic                addr_done;

    assign sclk_rise  = sclk_s & ~sclk_q;
    assign sclk_fall  = ~sclk_s & sclk_q;
    assign shift_next = {in_sr[LONGEST-2:0], si_s};
    assign shifting   = !cs_n_s && sclk_rise &&
                        (state == ST_CMD || state == ST_ADDR);
    assign cmd_done   = shifting && (state == ST_CMD)  && (bit_cnt == CMD_LAST);
    assign addr_done  = shifting && (state == ST_ADDR) && (bit_cnt == ADDR_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        if (cs_n_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_CMD;
                ST_CMD: begin
                    if (cmd_done) begin
                        state_nx = (shift_next[CMD_W-1:0] == READ_OPCODE[CMD_W-1:0])
                                   ? ST_ADDR : ST_IGNORE;
                    end
                end
                ST_ADDR: begin
                    if (addr_done) begin
                        state_nx = ST_DATA;
                    end
                end
                ST_DATA:   state_nx = ST_DATA;
                ST_IGNORE: state_nx = ST_IGNORE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr_load = addr_done;
        addr_word = shift_next[ADDR_W-1:0];
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            in_sr   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (cs_n_s || cmd_done || addr_done) begin
                bit_cnt <= '0;
            end else if (shifting) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (shifting) begin
                in_sr <= shift_next;
            end
        end
    end

endmodule

// File: rtl/segrd_seg_counter.sv
`timescale 1ns/1ps
module segrd_seg_counter #(
    parameter int ARRAY_AW = 20,
    parameter int OFS_W    = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [ARRAY_AW-1:0]  load_addr,
    input  logic                 step,
    output logic [ARRAY_AW-1:0]  cur_addr
);

    localparam int SEG_W = ARRAY_AW - OFS_W;
    localparam logic [OFS_W-1:0] OFS_LAST = '1;

    logic [SEG_W-1:0] seg_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
            ofs_q <= '0;
        end else if (load) begin
            seg_q <= load_addr[ARRAY_AW-1:OFS_W];
            ofs_q <= load_addr[OFS_W-1:0];
        end else if (step) begin
            ofs_q <= (ofs_q == OFS_LAST) ? '0 : ofs_q + OFS_W'(1);
        end
    end

    assign cur_addr = {seg_q, ofs_q};

endmodule

// File: rtl/segrd_tx.sv
`timescale 1ns/1ps
module segrd_tx #(
    parameter int          ARRAY_AW = 20,
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  FILL     = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 sclk_fall,
    input  logic [ARRAY_AW-1:0]  cur_addr,
    output logic                 step,
    output logic                 so_bit,
    output logic                 so_drive
);

    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int CHUNKS = (ARRAY_AW + BYTE_W - 1) / BYTE_W;

    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] out_sr;

    // computed array content: fold address chunks together with a fill constant
    function automatic logic [BYTE_W-1:0] byte_at(input logic [ARRAY_AW-1:0] a);
        logic [CHUNKS*BYTE_W-1:0] padded;
        logic [BYTE_W-1:0]        acc;
        padded = '0;
        padded[ARRAY_AW-1:0] = a;
        acc = FILL[BYTE_W-1:0];
        for (int k = 0; k < CHUNKS; k++) begin
            acc = acc ^ padded[k*BYTE_W +: BYTE_W];
        end
        return acc;
    endfunction

    assign step = active && sclk_fall && (bit_idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            out_sr   <= '0;
            so_drive <= 1'b0;
        end else if (!active) begin
            bit_idx  <= '0;
            out_sr   <= '0;
            so_drive <= 1'b0;
        end else if (sclk_fall) begin
            so_drive <= 1'b1;
            bit_idx  <= bit_idx + BIT_W'(1);
            out_sr   <= step ? byte_at(cur_addr) : {out_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign so_bit = so_drive & out_sr[BYTE_W-1];

endmodule

// File: rtl/seg_wrap_reader.sv
`timescale 1ns/1ps
module seg_wrap_reader
    import segrd_pkg::*;
#(
    parameter int          CMD_W       = 8,
    parameter int          ADDR_W      = 24,
    parameter int          ARRAY_AW    = 20,
    parameter int          OFS_W       = 9,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  READ_OPCODE = 8'h03,
    parameter logic [7:0]  FILL        = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so,
    output logic so_oe
);

    segrd_state_e          state;
    logic [2:0]            pins_s;
    logic                  cs_n_s;
    logic                  sclk_s;
    logic                  si_s;
    logic                  sclk_fall;
    logic                  addr_load;
    logic [ADDR_W-1:0]     addr_word;
    logic [ARRAY_AW-1:0]   load_addr;
    logic [ARRAY_AW-1:0]   cur_addr;
    logic                  tx_step;
    logic                  tx_active;

    segrd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, si}),
        .q     (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sclk_s = pins_s[1];
    assign si_s   = pins_s[0];

    segrd_fsm #(
        .CMD_W       (CMD_W),
        .ADDR_W      (ADDR_W),
        .READ_OPCODE (READ_OPCODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .si_s      (si_s),
        .state     (state),
        .sclk_fall (sclk_fall),
        .addr_load (addr_load),
        .addr_word (addr_word)
    );

    assign load_addr = addr_word[ARRAY_AW-1:0];
    assign tx_active = (state == ST_DATA);

    segrd_seg_counter #(
        .ARRAY_AW (ARRAY_AW),
        .OFS_W    (OFS_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (load_addr),
        .step      (tx_step),
        .cur_addr  (cur_addr)
    );

    segrd_tx #(
        .ARRAY_AW (ARRAY_AW),
        .BYTE_W   (8),
        .FILL     (FILL)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (tx_active),
        .sclk_fall (sclk_fall),
        .cur_addr  (cur_addr),
        .step      (tx_step),
        .so_bit    (so),
        .so_drive  (so_oe)
    );

endmodule

// File: rtl/segrd_checker.sv
`timescale 1ns/1ps
module segrd_checker
    import segrd_pkg::*;
#(
    parameter int ARRAY_AW = 20,
    parameter int OFS_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_s,
    input  segrd_state_e        state,
    input  logic                step,
    input  logic                addr_load,
    input  logic [ARRAY_AW-1:0] load_addr,
    input  logic [ARRAY_AW-1:0] cur_addr,
    input  logic                so_oe,
    input  logic                so
);

    logic [OFS_W-1:0]          ofs;
    logic [ARRAY_AW-OFS_W-1:0] seg;

    assign ofs = cur_addr[OFS_W-1:0];
    assign seg = cur_addr[ARRAY_AW-1:OFS_W];

    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s) && $past(cs_n_s, 2)) |-> (!so_oe && !so)); // R1

    AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (cur_addr == $past(load_addr))); // R5

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_load) |=> (ofs == OFS_W'($past(ofs) + OFS_W'(1)))); // R5

    AST_OFS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_load && (ofs == '1)) |=> (ofs == '0)); // R6

    AST_SEG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_load |=> $stable(seg)); // R6

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !addr_load) |=> $stable(ofs)); // R7

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !so_oe); // R9

    AST_DRIVE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> ($past(state) == ST_DATA)); // R10

endmodule

bind seg_wrap_reader segrd_checker #(
    .ARRAY_AW (ARRAY_AW),
    .OFS_W    (OFS_W)
) u_segrd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .state     (state),
    .step      (tx_step),
    .addr_load (addr_load),
    .load_addr (load_addr),
    .cur_addr  (cur_addr),
    .so_oe     (so_oe),
    .so        (so)
);

// File: tb/seg_wrap_reader_bench.sv
`timescale 1ns/1ps
module seg_wrap_reader_bench;

    localparam int HALF = 4;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n;
    logic sclk;
    logic si;
    logic so;
    logic so_oe;

    int   checks   = 0;
    int   failures = 0;
    bit   mon_on   = 1'b0;
    bit   ig_on    = 1'b0;
    int   nb       = 0;
    logic [7:0] cur_byte = '0;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    seg_wrap_reader u_seg_wrap_reader (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    function automatic logic [7:0] model(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b);
        si = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // driver: queue expected bytes, then clock the access
    task automatic burst(input logic [7:0] cmd, input logic [23:0] a,
                         input int nbits, input string tag);
        logic [31:0] hdr;
        hdr = {cmd, a};
        if (cmd == 8'h03) begin
            for (int i = 0; i < nbits / 8; i++) begin
                exp_t e;
                e.val = model({a[19:9], 9'(a[8:0] + 9'(i))});
                e.tag = tag;
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 31; i >= 0; i--) begin
            spi_bit(hdr[i]);
        end
        if (cmd == 8'h03) mon_on = 1'b1;
        else              ig_on  = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            spi_bit(1'b0);
        end
        mon_on = 1'b0;
        ig_on  = 1'b0;
        nb     = 0;
        cs_n   = 1'b1;
        repeat (6) @(negedge clk);
        chk(so_oe === 1'b0, "R1 so_oe after deselect", so_oe, 0);
        chk(so === 1'b0, "R1 so after deselect", so, 0);
        chk(exp_q.size() == 0, {"R3 bytes missing: ", tag}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // abort inside the header
    task automatic header_abort(input logic [7:0] cmd, input logic [23:0] a,
                                input int nbits);
        logic [31:0] hdr;
        hdr = {cmd, a};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 31; i > 31 - nbits; i--) begin
            spi_bit(hdr[i]);
        end
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(so_oe === 1'b0, "R8 so_oe after header abort", so_oe, 0);
    endtask

    // monitor: sample so at each host SCLK rise
    always @(posedge sclk) begin
        if (mon_on) begin
            chk(so_oe === 1'b1, "R10 so_oe during read", so_oe, 1);
            cur_byte = {cur_byte[6:0], so};
            nb++;
            if (nb == 8) begin
                nb = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", cur_byte, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cur_byte === e.val, e.tag, cur_byte, e.val);
                end
            end
        end
        if (ig_on) begin
            chk(so_oe === 1'b0, "R9 so_oe after unknown opcode", so_oe, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b0;
        si    = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_oe === 1'b0, "R1 reset so_oe", so_oe, 0);
        chk(so === 1'b0, "R1 reset so", so, 0);

        burst(8'h03, 24'h000000, 32, "R2 R3 R4 read from 0");
        burst(8'h03, 24'hF12345, 48, "R4 R5 top nibble ignored, mid offset");
        burst(8'h03, 24'h0ABDF8, 160, "R6 wrap at segment end");
        burst(8'h03, 24'h07A1F0, 520 * 8, "R7 continuous over a full lap");

        header_abort(8'h03, 24'h055555, 20);
        burst(8'h03, 24'h012301, 24, "R8 restart after header abort");
        burst(8'h03, 24'h0C3FFE, 20, "R8 abort mid byte");
        burst(8'h03, 24'h0C3FFE, 24, "R8 restart after data abort");

        burst(8'h0B, 24'h000100, 16, "R9 unknown opcode 0x0B");
        burst(8'h02, 24'h000100, 16, "R9 unknown opcode 0x02");
        burst(8'h03, 24'h000100, 16, "R9 decode after unknown opcode");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule